// File: doc/BRIEF.md
# Timer Event Capture Unit

This block watches one of two event lines (an external pin or an internal comparator output). When the selected line makes a transition of the programmed polarity, it stores the present value of a free-running 16-bit counter in a capture register. In the same cycle it raises a capture flag, and when interrupts are enabled the flag drives an interrupt request. The flag clears when the interrupt is acknowledged, or when software writes a one to it.

Both event lines pass through their own two-flop synchronizer. The source multiplexer sits after the synchronizers. Because of this, changing the source while the two lines sit at different levels gives an edge that the detector sees at once, and that edge can trigger a capture. An optional glitch filter accepts a new level only after four consecutive matching samples. The capture register can also act as a software-written top value. In that mode captures are blocked so that the stored value is kept.

Top module: `evt_capture_unit`

## Requirements
- R1: With `edge_rise`=1 only a 0-to-1 transition of the selected event level captures; with `edge_rise`=0 only a 1-to-0 transition captures. A transition of the other polarity leaves `cap_flag` low.
- R2: On a capture, `cap_val` takes the `cnt_val` value present on the capturing clock edge.
- R3: `cap_flag` rises on the same clock edge on which `cap_val` is loaded.
- R4: `irq` is high exactly when `cap_flag` and `irq_en` are both high.
- R5: `irq_ack`=1 on a clock edge clears `cap_flag`.
- R6: A strobe `flag_wr`=1 with `flag_wdata`=1 clears `cap_flag`; with `flag_wdata`=0 the flag is unchanged.
- R7: `src_cmp`=0 selects `pin_evt` and `src_cmp`=1 selects `cmp_evt`. Transitions on the unselected line cause no capture.
- R8: Changing `src_cmp` while the two synchronized lines differ is an edge of the selected level. It captures on the very next clock edge when its polarity matches `edge_rise`.
- R9: With `filt_en`=0 an input transition is captured on the third clock edge after it, using the counter value after the second edge. A one-cycle pulse is enough to capture.
- R10: With `filt_en`=1 the level must be seen on four consecutive samples. This adds four clock edges to the R9 latency. A pulse shorter than four samples causes no capture.
- R11: While `top_mode`=1, `top_wr` loads `top_wdata` into `cap_val` and event edges neither load `cap_val` nor set the flag. While `top_mode`=0, `top_wr` has no effect.
- R12: When a capture and a flag clear (acknowledge or software write) fall on the same edge, the flag ends up set.
- R13: After reset `cap_val`=0, `cap_flag`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Free-running counter value |
| pin_evt | input | 1 | External event pin (asynchronous) |
| cmp_evt | input | 1 | Comparator output event (asynchronous) |
| src_cmp | input | 1 | Event source: 0 pin, 1 comparator |
| edge_rise | input | 1 | Edge polarity: 1 rising, 0 falling |
| filt_en | input | 1 | Enable four-sample glitch filter |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt serviced, clears flag |
| flag_wr | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Written flag bit, 1 clears |
| top_mode | input | 1 | Capture register holds software top value |
| top_wr | input | 1 | Write strobe for top value |
| top_wdata | input | 16 | Top value to write |
| cap_val | output | 16 | Captured or written value |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
A pin transition reaches the flag and `cap_val` on the third edge, or the seventh when filtering is on. The bench samples after every edge and requires the flag to stay low until exactly that edge. It then compares `cap_val` with the counter value it recorded at the stimulus plus two (or six). A source switch captures on the first edge, and the control inputs (`irq_en`, acknowledge, software clear, top write) act within one edge, with `irq` checked combinationally. All inputs change at the falling edge and all outputs are sampled at the falling edge.

// File: rtl/icu_pkg.sv
// Shared parameters and types for the timer event capture unit.
package icu_pkg;
    localparam int CNT_W        = 16;
    localparam int SYNC_STAGES  = 2;
    localparam int FILT_SAMPLES = 4;
    localparam int N_SRC        = 2;
    localparam int SRC_PIN      = 0;
    localparam int SRC_CMP      = 1;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/icu_sync.sv
// Multi-bit, multi-stage synchronizer for independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherency is implied.
module icu_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first flop samples the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // later flops resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
// Glitch filter: the held level follows the input only after SAMPLES
// consecutive samples differ from it. Bypassed when filt_en is low.
// Assumes din is already synchronous to clk.
module icu_filter #(
    parameter int SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic filt_en,
    output logic dout
);
    localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    logic          held_q;
    logic [CW-1:0] run_q;

    // count consecutive differing samples and adopt the level at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            run_q  <= '0;
        end else if (din == held_q) begin
            run_q  <= '0;
        end else if (run_q == LAST) begin
            held_q <= din;
            run_q  <= '0;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign dout = filt_en ? held_q : din;

    // R10
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din == held_q) |=> $stable(held_q));
endmodule

// File: rtl/icu_edge.sv
// Edge detector: flags a transition of the event level that matches the
// programmed polarity. Assumes level is synchronous to clk.
module icu_edge import icu_pkg::*; (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  edge_pol_e pol,
    output logic      hit
);
    logic prev_q;

    // remember the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // compare current and previous level against the polarity
    always_comb begin
        if (pol == EDGE_RISE) hit = level & ~prev_q;
        else                  hit = ~level & prev_q;
    end

    // R1
    no_double_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pol == EDGE_RISE) |=> !(hit && pol == EDGE_RISE));
endmodule

// File: rtl/icu_cap_reg.sv
// Capture register and flag. Loads the counter on a hit unless in top-value
// mode, where only software writes load it. A set of the flag takes
// priority over any clear on the same edge.
module icu_cap_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic         top_mode,
    input  logic         top_wr,
    input  logic [W-1:0] top_wdata,
    input  logic [W-1:0] cnt_val,
    input  logic         irq_ack,
    input  logic         flag_wr,
    input  logic         flag_wdata,
    output logic [W-1:0] cap_val,
    output logic         cap_flag
);
    logic cap_go;
    logic clr_go;

    assign cap_go = hit & ~top_mode;
    assign clr_go = irq_ack | (flag_wr & flag_wdata);

    // capture register: counter snapshot or software top value
    always_ff @(posedge clk) begin
        if (!rst_n)                  cap_val <= '0;
        else if (cap_go)             cap_val <= cnt_val;
        else if (top_mode && top_wr) cap_val <= top_wdata;
    end

    // capture flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_flag <= 1'b0;
        else if (cap_go) cap_flag <= 1'b1;
        else if (clr_go) cap_flag <= 1'b0;
    end

    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !top_mode) |=> (cap_val == $past(cnt_val)));
    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !top_mode) |=> cap_flag);
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !hit) |=> !cap_flag);
    // R11
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode && !top_wr) |=> $stable(cap_val));
endmodule

// File: rtl/evt_capture_unit.sv
// Timer event capture unit: synchronizes two event lines, selects one,
// optionally filters it, detects the programmed edge and snapshots the
// counter. Assumes cnt_val is synchronous to clk.
module evt_capture_unit import icu_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             pin_evt,
    input  logic             cmp_evt,
    input  logic             src_cmp,
    input  logic             edge_rise,
    input  logic             filt_en,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             top_mode,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_wdata,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             irq
);
    logic [N_SRC-1:0] raw_evt;
    logic [N_SRC-1:0] sync_evt;
    logic             sel_lvl;
    logic             filt_lvl;
    logic             hit;

    assign raw_evt[SRC_PIN] = pin_evt;
    assign raw_evt[SRC_CMP] = cmp_evt;

    icu_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_evt), .q(sync_evt)
    );

    // source mux placed after the synchronizers
    assign sel_lvl = src_cmp ? sync_evt[SRC_CMP] : sync_evt[SRC_PIN];

    icu_filter #(.SAMPLES(FILT_SAMPLES)) u_filter (
        .clk(clk), .rst_n(rst_n), .din(sel_lvl), .filt_en(filt_en),
        .dout(filt_lvl)
    );

    icu_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level(filt_lvl),
        .pol(edge_pol_e'(edge_rise)), .hit(hit)
    );

    icu_cap_reg #(.W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .hit(hit), .top_mode(top_mode),
        .top_wr(top_wr), .top_wdata(top_wdata), .cnt_val(cnt_val),
        .irq_ack(irq_ack), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .cap_val(cap_val), .cap_flag(cap_flag)
    );

    assign irq = cap_flag & irq_en;

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: tb/evt_capture_unit_tb.sv
`timescale 1ns/1ps
module evt_capture_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt;
    logic        pin_evt, cmp_evt, src_cmp, edge_rise, filt_en, irq_en;
    logic        irq_ack, flag_wr, flag_wdata, top_mode, top_wr;
    logic [15:0] top_wdata;
    logic [15:0] cap_val;
    logic        cap_flag, irq;
    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] c0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cnt <= 16'h1000;
        else        cnt <= cnt + 16'd1;
    end

    evt_capture_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .pin_evt(pin_evt),
        .cmp_evt(cmp_evt), .src_cmp(src_cmp), .edge_rise(edge_rise),
        .filt_en(filt_en), .irq_en(irq_en), .irq_ack(irq_ack),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .top_mode(top_mode),
        .top_wr(top_wr), .top_wdata(top_wdata), .cap_val(cap_val),
        .cap_flag(cap_flag), .irq(irq)
    );

    // fields: [7]src_cmp [6]edge_rise [5]filt_en [4]pin from [3]pin to
    //         [2]cmp from [1]cmp to [0]capture expected
    localparam logic [7:0] VECS [10] = '{
        8'b01001001, 8'b01010000, 8'b00010001, 8'b00001000, 8'b11000011,
        8'b11001000, 8'b01000010, 8'b01101001, 8'b10100101, 8'b00110001
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic sw_clear();
        flag_wr = 1'b1; flag_wdata = 1'b1;
        step(1);
        flag_wr = 1'b0; flag_wdata = 1'b0;
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin_evt = 0; cmp_evt = 0; src_cmp = 0; edge_rise = 1;
        filt_en = 0; irq_en = 1; irq_ack = 0; flag_wr = 0; flag_wdata = 0;
        top_mode = 0; top_wr = 0; top_wdata = '0;
        step(4);
        // R13 reset state, irq_en held high
        chk("R13 cap_val", 32'(cap_val), 32'h0);
        chk("R13 cap_flag", 32'(cap_flag), 32'h0);
        chk("R13 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        irq_en = 1'b0;
        step(2);

        // table walk: R1 R2 R3 R7 R9 R10
        for (int v = 0; v < 10; v++) begin
            logic [7:0] e;
            int lat;
            e = VECS[v];
            src_cmp = e[7]; edge_rise = e[6]; filt_en = e[5];
            pin_evt = e[4]; cmp_evt = e[2];
            step(10);
            sw_clear();
            lat = e[5] ? 7 : 3;
            c0 = cnt;
            pin_evt = e[3]; cmp_evt = e[1];
            if (e[0]) begin
                for (int k = 1; k < lat; k++) begin
                    step(1);
                    chk(e[5] ? "R10 flag early" : "R9 flag early", 32'(cap_flag), 32'h0);
                end
                step(1);
                chk("R3 flag on capture edge", 32'(cap_flag), 32'h1);
                chk("R2 captured count", 32'(cap_val), 32'(c0 + 16'(lat - 1)));
            end else begin
                step(10);
                chk("R1 R7 no capture", 32'(cap_flag), 32'h0);
            end
        end

        // R8 source switch creates an edge
        filt_en = 0; edge_rise = 1; src_cmp = 0; pin_evt = 1; cmp_evt = 0;
        step(10);
        sw_clear();
        src_cmp = 1;
        step(1);
        chk("R8 switch falling with rise polarity", 32'(cap_flag), 32'h0);
        src_cmp = 0;
        c0 = cnt;
        step(1);
        chk("R8 switch rising captures flag", 32'(cap_flag), 32'h1);
        chk("R8 switch rising captures value", 32'(cap_val), 32'(c0));

        // R12 set beats simultaneous clears
        edge_rise = 0; src_cmp = 1;
        irq_ack = 1; flag_wr = 1; flag_wdata = 1;
        c0 = cnt;
        step(1);
        irq_ack = 0; flag_wr = 0; flag_wdata = 0;
        chk("R12 flag kept", 32'(cap_flag), 32'h1);
        chk("R12 value", 32'(cap_val), 32'(c0));

        // R6 software clear
        flag_wr = 1; flag_wdata = 0;
        step(1);
        flag_wr = 0;
        chk("R6 write zero no effect", 32'(cap_flag), 32'h1);
        sw_clear();
        chk("R6 write one clears", 32'(cap_flag), 32'h0);

        // R4 and R5
        edge_rise = 1; src_cmp = 0;
        step(1);
        irq_en = 0;
        #1;
        chk("R4 flag set for irq test", 32'(cap_flag), 32'h1);
        chk("R4 irq masked", 32'(irq), 32'h0);
        irq_en = 1;
        #1;
        chk("R4 irq raised", 32'(irq), 32'h1);
        @(negedge clk);
        irq_ack = 1;
        step(1);
        irq_ack = 0;
        chk("R5 ack clears flag", 32'(cap_flag), 32'h0);
        chk("R5 irq drops", 32'(irq), 32'h0);

        // R11 top-value mode
        top_mode = 1; top_wr = 1; top_wdata = 16'hBEEF;
        step(1);
        top_wr = 0;
        chk("R11 top write", 32'(cap_val), 32'hBEEF);
        edge_rise = 0; src_cmp = 1;
        step(3);
        chk("R11 capture blocked flag", 32'(cap_flag), 32'h0);
        chk("R11 capture blocked value", 32'(cap_val), 32'hBEEF);
        top_mode = 0; top_wr = 1; top_wdata = 16'h1234;
        step(1);
        top_wr = 0;
        chk("R11 write ignored outside top mode", 32'(cap_val), 32'hBEEF);

        // R10 short glitch rejected; R9 same glitch passes unfiltered
        src_cmp = 0; edge_rise = 1; filt_en = 1; pin_evt = 0;
        step(12);
        sw_clear();
        pin_evt = 1;
        step(3);
        pin_evt = 0;
        step(12);
        chk("R10 three-sample glitch rejected", 32'(cap_flag), 32'h0);
        filt_en = 0;
        step(4);
        sw_clear();
        pin_evt = 1;
        step(1);
        pin_evt = 0;
        step(10);
        chk("R9 one-cycle pulse captured", 32'(cap_flag), 32'h1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule